// File: doc/BRIEF.md
# Bit-Plane Frame Buffer Write Address Generator

This block computes the write address for a frame buffer that holds video data already split into bit planes. Each incoming word carries the bits of one weight for eight RGB pixels. The block counts these words with a chain of four wrapping counters. The bit-weight index changes fastest, then the eight-pixel column group, then the scan line inside an area, then the area. The bit-weight index is placed in the most significant address bits. As a result, every bit of a given weight in one frame lands in one contiguous segment of memory. A display reader can then fetch one weight at a time.

The generator accepts a word on each cycle where the write-valid input is high. It presents that word's address one cycle later, together with an address-valid strobe. When the last word of a frame is addressed, it raises a one-cycle frame-end pulse, which a buffer-swap controller can use. A vertical-sync input returns all counters to the frame origin so that a disturbed stream realigns on the next frame. With the default sizes (8 weights, 100 column groups, 8 lines per area, 32 areas) the address is 18 bits wide.

Top module: `bitplane_wr_addr_gen`

## Requirements
- R1: The output address is the concatenation, from most to least significant, of weight index, area index, line-in-area index and column-group index. Each field is clog2 of its count wide, so the defaults give bits 17:15, 14:10, 9:7 and 6:0.
- R2: While reset is high and in the first cycle after it, `wr_addr` is 0 and both `wr_addr_vld` and `frame_end` are 0. The first word accepted after reset is given address 0.
- R3: Each accepted word advances the weight index by one. When the weight index is at its count minus one, it wraps to 0 and the column-group index advances.
- R4: When the column-group index wraps from its count minus one (63h by default), it returns to 0 and the line-in-area index advances.
- R5: When the line-in-area index wraps from its count minus one, it returns to 0 and the area index advances.
- R6: When the word with every field at its maximum is addressed, `frame_end` is high for exactly that cycle. The next accepted word gets address 0.
- R7: A cycle with `wr_valid` low accepts no word. The following cycle shows `wr_addr_vld` and `frame_end` low with `wr_addr` unchanged, and the address sequence resumes where it stopped.
- R8: `vsync` high returns all four indices to 0. A word presented in the same cycle as `vsync` is dropped (no `wr_addr_vld`). The next accepted word is given address 0.
- R9: A word accepted at a rising edge has its address and `wr_addr_vld` on the outputs from that edge until the next one (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsync | input | 1 | Frame realignment; clears all indices |
| wr_valid | input | 1 | A bit-plane word is present this cycle |
| wr_addr | output | ADDR_W | Registered write address of the last accepted word |
| wr_addr_vld | output | 1 | `wr_addr` belongs to a word accepted at the last edge |
| frame_end | output | 1 | The addressed word is the last one of the frame |

## Verification
A wrong carry inside the counter chain shows up at the address port on the first word after the faulty wrap. Because the weight index turns over every few words, a carry error into the column field appears within one weight cycle. Errors in the line and area carries appear at the first column or line rollover. A counter that fails to clear on `vsync`, or that steps on an idle cycle, shifts every later address. It also moves the `frame_end` pulse off the all-maximum word, so a near-exhaustive sweep of whole frames catches it within the same frame.

// File: rtl/bpw_pkg.sv
package bpw_pkg;

  // Width of an index that counts 0..n-1, never below one bit.
  function automatic int cnt_w(input int n);
    cnt_w = (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Stage order of the counter chain: 0 weight, 1 column, 2 line, 3 area.
  localparam int NSTG = 4;

  function automatic int stage_mod(input int i, input int f, input int c,
                                   input int r, input int a);
    case (i)
      0:       stage_mod = f;
      1:       stage_mod = c;
      2:       stage_mod = r;
      default: stage_mod = a;
    endcase
  endfunction

endpackage

// File: rtl/wrap_ctr.sv
module wrap_ctr #(
  parameter int MOD = 8,
  parameter int W   = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         last
);

  localparam logic [W-1:0] TOP = W'(MOD - 1);

  assign last = (value == TOP);

  always_ff @(posedge clk) begin
    if (rst || clr)  value <= '0;
    else if (step)   value <= last ? '0 : value + 1'b1;
  end

  // R1: an index never leaves its field's legal range
  a_r1_ctr_in_range: assert property (@(posedge clk) disable iff (rst)
    value <= TOP);

  // R8: a clear leaves the index at zero
  a_r8_clr_zero: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> value == '0);

endmodule

// File: rtl/addr_out_reg.sv
module addr_out_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] next_addr,
  input  logic         frame_last,
  output logic [W-1:0] addr,
  output logic         vld,
  output logic         done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      vld  <= 1'b0;
      done <= 1'b0;
    end else begin
      vld  <= load;
      done <= load & frame_last;
      if (load) addr <= next_addr;
    end
  end

  // R7: an idle cycle produces no strobe and keeps the address
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> (!vld && !done && $stable(addr)));

  // R6: frame end is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/bitplane_wr_addr_gen.sv
module bitplane_wr_addr_gen
  import bpw_pkg::*;
#(
  parameter int FIELD_CNT = 8,
  parameter int COL_CNT   = 100,
  parameter int ROW_CNT   = 8,
  parameter int AREA_CNT  = 32,
  localparam int FW      = cnt_w(FIELD_CNT),
  localparam int CW      = cnt_w(COL_CNT),
  localparam int RW      = cnt_w(ROW_CNT),
  localparam int AW      = cnt_w(AREA_CNT),
  localparam int ADDR_W  = FW + AW + RW + CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_addr_vld,
  output logic              frame_end
);

  localparam int MAXW = (FW > CW ? FW : CW) > (RW > AW ? RW : AW)
                      ? (FW > CW ? FW : CW) : (RW > AW ? RW : AW);
  localparam logic [ADDR_W-1:0] ADDR_LAST =
    {FW'(FIELD_CNT-1), AW'(AREA_CNT-1), RW'(ROW_CNT-1), CW'(COL_CNT-1)};

  logic            accept;
  logic [NSTG:0]   carry;
  logic [NSTG-1:0] at_last;
  logic [MAXW-1:0] cval [NSTG];
  logic [ADDR_W-1:0] cur_addr;

  assign accept   = wr_valid & ~vsync;
  assign carry[0] = accept;

  for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
    localparam int M = stage_mod(gi, FIELD_CNT, COL_CNT, ROW_CNT, AREA_CNT);
    localparam int W = cnt_w(M);
    logic [W-1:0] v;
    wrap_ctr #(.MOD(M), .W(W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .clr   (vsync),
      .step  (carry[gi]),
      .value (v),
      .last  (at_last[gi])
    );
    assign cval[gi]     = MAXW'(v);
    assign carry[gi+1]  = carry[gi] & at_last[gi];
  end

  // Weight on top, then area, line, column group.
  assign cur_addr = {cval[0][FW-1:0], cval[3][AW-1:0],
                     cval[2][RW-1:0], cval[1][CW-1:0]};

  addr_out_reg #(.W(ADDR_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .next_addr  (cur_addr),
    .frame_last (carry[NSTG]),
    .addr       (wr_addr),
    .vld        (wr_addr_vld),
    .done       (frame_end)
  );

  logic [FW-1:0]        o_field;
  logic [ADDR_W-FW-1:0] o_rest;
  assign o_field = wr_addr[ADDR_W-1 -: FW];
  assign o_rest  = wr_addr[ADDR_W-FW-1:0];

  // R3: back-to-back words below the top weight only bump the weight field
  a_r3_field_step: assert property (@(posedge clk) disable iff (rst)
    (wr_addr_vld && $past(wr_addr_vld) && $past(o_field) != FW'(FIELD_CNT-1))
    |-> (o_field == FW'($past(o_field) + 1'b1) && o_rest == $past(o_rest)));

  // R6: the frame-end pulse marks the all-maximum address
  a_r6_done_at_last: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> (wr_addr_vld && wr_addr == ADDR_LAST));

  // R8: first word after a sync gets the origin address
  a_r8_sync_restart: assert property (@(posedge clk) disable iff (rst)
    ($past(vsync, 2) && $past(wr_valid) && !$past(vsync)) |-> wr_addr == '0);

endmodule

// File: tb/bitplane_wr_addr_gen_tb_top.sv
module bitplane_wr_addr_gen_tb_top;

  localparam int F = 4, C = 5, R = 2, A = 3;
  localparam int TOTAL = F * C * R * A;
  localparam int AWID  = 8;  // 2 + 2 + 1 + 3

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vsync = 1'b0;
  logic wr_valid = 1'b0;
  logic [AWID-1:0] wr_addr;
  logic wr_addr_vld, frame_end;

  int total = 0, bad = 0;
  int k = 0;
  logic [AWID-1:0] last_addr = '0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  bitplane_wr_addr_gen #(.FIELD_CNT(F), .COL_CNT(C), .ROW_CNT(R), .AREA_CNT(A)) dut_i (
    .clk(clk), .rst(rst), .vsync(vsync), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_addr_vld(wr_addr_vld), .frame_end(frame_end)
  );

  // R1: weight bits 7:6, area 5:4, line 3, column group 2:0
  function automatic logic [AWID-1:0] enc(input int n);
    int f, c, r, a;
    f = n % F; c = (n / F) % C; r = (n / (F * C)) % R; a = (n / (F * C * R)) % A;
    return AWID'(f * 64 + a * 16 + r * 8 + c);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: inputs applied now (away from the edge), outputs checked after it.
  task automatic cyc(input logic v, input logic vs);
    logic acc;
    wr_valid = v; vsync = vs;
    @(posedge clk); #1;
    acc = v && !vs;
    chk("R9 R7 R8 vld", int'(wr_addr_vld), int'(acc));
    if (acc) begin
      chk("R1 R3 R4 R5 addr", int'(wr_addr), int'(enc(k)));
      chk("R6 frame_end", int'(frame_end), int'(k == TOTAL - 1));
      last_addr = enc(k);
      k = (k + 1) % TOTAL;
    end else begin
      chk("R7 addr hold", int'(wr_addr), int'(last_addr));
      chk("R7 R8 frame_end idle", int'(frame_end), 0);
    end
    if (vs) k = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset addr", int'(wr_addr), 0);
    chk("R2 reset vld", int'(wr_addr_vld), 0);
    chk("R2 reset frame_end", int'(frame_end), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 post-reset vld", int'(wr_addr_vld), 0);
    // Two back-to-back frames: every wrap of R3 R4 R5 and R6 twice
    for (int i = 0; i < 2 * TOTAL; i++) cyc(1'b1, 1'b0);
    // Gapped frame: every third cycle idle (R7)
    for (int i = 0; i < TOTAL + TOTAL / 2; i++) cyc(i % 3 != 1, 1'b0);
    // Sync while idle mid-frame (R8)
    for (int i = 0; i < 37; i++) cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    for (int i = 0; i < 50; i++) cyc(1'b1, 1'b0);
    // Sync together with a valid word: word dropped (R8)
    cyc(1'b1, 1'b1);
    for (int i = 0; i < TOTAL + 3; i++) cyc(1'b1, 1'b0);
    // Long idle stretch then resume (R7)
    for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0);
    for (int i = 0; i < TOTAL; i++) cyc(i % 5 != 0, 1'b0);
    // Reset mid-frame restarts at origin (R2)
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    k = 0; last_addr = '0;
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule